// File: doc/BRIEF.md
# Memory-mapped periodic tick timer

The block is a down-counting interval timer reached through a 32-bit word-addressed register port. Software programs a reload value and sets the enable bit. The counter then loads that value and decrements once for each tick of the selected source. That source is either every processor clock or a pulse on a separate reference tick input. When the count moves from one to zero, a sticky flag sets and, if enabled, a one-cycle interrupt pulse goes out. On the next tick the counter loads the reload value again.

Every access gets a registered response one cycle after the request. Accesses marked unprivileged get an error response and change nothing. A zero reload value makes the timer stop after a single expiry. Reading the control register clears the flag. Any write to the current-value register restarts the count.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current-value reads are all zero, irq_o is low and rsp_valid_o is low.
- R2: Every request gets rsp_valid_o exactly one cycle later. The word offsets are: control 0x0, reload 0x4, current value 0x8, calibration 0xC. The reload register keeps CNT_W bits and reads back zero-extended. Calibration always reads 10000. Write responses carry zero data.
- R3: Control bits are: bit 0 enable, bit 1 interrupt enable, bit 2 source select, bit 16 count flag. A control write changes only bits 2:0. All other control bits read as zero.
- R4: Setting enable from 0 to 1 loads the reload value. While enabled, the counter decrements by one per tick. Source select 1 ticks on every clock; source select 0 ticks on each cycle with ref_tick_i high.
- R5: The tick that moves the count from 1 to 0 sets the count flag. If interrupt enable is set, the same tick raises irq_o for exactly one cycle. The current value reads 0 until the next tick, which reloads it.
- R6: If the reload value is zero at an expiry, the enable bit clears itself, so only one expiry occurs.
- R7: A control read returns the current count flag and clears it.
- R8: A write of any data to the current-value register clears the count flag. If enabled, it also restarts the count from the reload value.
- R9: The current value reads zero while the timer is disabled.
- R10: An access with req_user_i high returns rsp_err_o high with zero data and changes no register.
- R11: Changing the source select bit while enable stays set reloads the counter at once.
- R12: Reads of unmapped offsets return zero with no error. Writes to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference tick enable, one cycle per tick |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_user_i | input | 1 | Access is unprivileged |
| req_addr_i | input | ADDR_W | Byte offset of the word |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | DATA_W | Read data |
| rsp_err_o | output | 1 | Bus error response |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A request presented before a rising edge gets its response on the outputs right after that edge. The read data shows register state from before that edge. The register and counter effects of a write, and of a reference tick, take effect on that same edge. The interrupt pulse is high in the cycle after the edge that moved the count from 1 to 0, and low again one edge later. The bench changes its inputs on falling edges, so each access or tick spans exactly one rising edge. It samples on the following falling edge, and it derives every expected count by counting those edges.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned OFF_CTRL = 'h0;
  localparam int unsigned OFF_LOAD = 'h4;
  localparam int unsigned OFF_CUR  = 'h8;
  localparam int unsigned OFF_CAL  = 'hC;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_INT  = 1;
  localparam int unsigned BIT_SRC  = 2;
  localparam int unsigned BIT_FLAG = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_LOAD,
    SEL_CUR,
    SEL_CAL
  } reg_sel_e;
endpackage

// File: rtl/tick_timer_bus.sv
module tick_timer_bus
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_user_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] ctrl_rd_i,
  input  logic [DATA_W-1:0] load_rd_i,
  input  logic [DATA_W-1:0] cur_rd_i,
  input  logic [DATA_W-1:0] cal_rd_i,
  output reg_sel_e          sel_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  logic              ok;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    if (req_addr_i == ADDR_W'(OFF_CTRL))      sel_o = SEL_CTRL;
    else if (req_addr_i == ADDR_W'(OFF_LOAD)) sel_o = SEL_LOAD;
    else if (req_addr_i == ADDR_W'(OFF_CUR))  sel_o = SEL_CUR;
    else if (req_addr_i == ADDR_W'(OFF_CAL))  sel_o = SEL_CAL;
    else                                      sel_o = SEL_NONE;
  end

  // unprivileged accesses are dropped here, so nothing downstream sees them
  assign ok   = req_valid_i && !req_user_i;
  assign wr_o = ok && req_write_i;
  assign rd_o = ok && !req_write_i;

  always_comb begin
    rdata_d = '0;
    if (rd_o) begin
      unique case (sel_o)
        SEL_CTRL: rdata_d = ctrl_rd_i;
        SEL_LOAD: rdata_d = load_rd_i;
        SEL_CUR:  rdata_d = cur_rd_i;
        SEL_CAL:  rdata_d = cal_rd_i;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && req_user_i;
      rsp_rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  reg_sel_e          sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              expire_i,
  output logic              en_o,
  output logic              int_o,
  output logic              src_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_o,
  output logic              ctrl_wr_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [DATA_W-1:0] load_rd_o
);
  logic en_q, int_q, src_q, flag_q, irq_q;
  logic [CNT_W-1:0] reload_q;
  logic ctrl_wr, load_wr, cur_wr, ctrl_rd;
  logic new_en, new_src;

  assign ctrl_wr = wr_i && (sel_i == SEL_CTRL);
  assign load_wr = wr_i && (sel_i == SEL_LOAD);
  assign cur_wr  = wr_i && (sel_i == SEL_CUR);
  assign ctrl_rd = rd_i && (sel_i == SEL_CTRL);
  assign new_en  = wdata_i[BIT_EN];
  assign new_src = wdata_i[BIT_SRC];

  // load on enable rise, on source change while running, or on restart write
  assign load_o = (ctrl_wr && new_en && (!en_q || (new_src != src_q)))
                || (cur_wr && en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      int_q    <= 1'b0;
      src_q    <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= new_en;
        int_q <= wdata_i[BIT_INT];
        src_q <= new_src;
      end else if (expire_i && (reload_q == '0)) begin
        en_q <= 1'b0;
      end
      // a new expiry wins over a clearing access in the same cycle
      if (expire_i)                flag_q <= 1'b1;
      else if (ctrl_rd || cur_wr) flag_q <= 1'b0;
      irq_q <= expire_i && int_q;
      if (load_wr) reload_q <= wdata_i;
    end
  end

  always_comb begin
    ctrl_rd_o           = '0;
    ctrl_rd_o[BIT_EN]   = en_q;
    ctrl_rd_o[BIT_INT]  = int_q;
    ctrl_rd_o[BIT_SRC]  = src_q;
    ctrl_rd_o[BIT_FLAG] = flag_q;
  end

  assign load_rd_o = DATA_W'(reload_q);
  assign en_o      = en_q;
  assign int_o     = int_q;
  assign src_o     = src_q;
  assign flag_o    = flag_q;
  assign reload_o  = reload_q;
  assign ctrl_wr_o = ctrl_wr;
  assign irq_o     = irq_q;
endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             src_i,
  input  logic             ref_tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o,
  output logic             expire_o,
  output logic [CNT_W-1:0] cur_o
);
  logic [CNT_W-1:0] cur_q, cur_d;

  assign tick_o = src_i ? 1'b1 : ref_tick_i;

  always_comb begin
    cur_d    = cur_q;
    expire_o = 1'b0;
    if (load_i) begin
      cur_d = reload_i;
    end else if (en_i && tick_o) begin
      if (cur_q == '0) begin
        // zero reload: counting from 0 is itself the single expiry
        if (reload_i == '0) expire_o = 1'b1;
        else                cur_d    = reload_i;
      end else if (cur_q == CNT_W'(1)) begin
        cur_d    = '0;
        expire_o = 1'b1;
      end else begin
        cur_d = cur_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= cur_d;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned CAL_VAL = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_user_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              bus_wr, bus_rd;
  logic              ctrl_en, ctrl_int, ctrl_src, cnt_flag;
  logic              load_req, ctrl_wr, expire, tick_en;
  logic [CNT_W-1:0]  reload_val, cur_val;
  logic [DATA_W-1:0] ctrl_rd, load_rd, cur_rd, cal_rd;

  generate
    if (CNT_W < DATA_W) begin : g_wdata_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^req_wdata_i[DATA_W-1:CNT_W];
    end
  endgenerate

  assign cur_rd = ctrl_en ? DATA_W'(cur_val) : '0;
  assign cal_rd = DATA_W'(CAL_VAL);

  tick_timer_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_user_i  (req_user_i),
    .req_addr_i  (req_addr_i),
    .ctrl_rd_i   (ctrl_rd),
    .load_rd_i   (load_rd),
    .cur_rd_i    (cur_rd),
    .cal_rd_i    (cal_rd),
    .sel_o       (sel),
    .wr_o        (bus_wr),
    .rd_o        (bus_rd),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  tick_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .wr_i      (bus_wr),
    .rd_i      (bus_rd),
    .wdata_i   (req_wdata_i[CNT_W-1:0]),
    .expire_i  (expire),
    .en_o      (ctrl_en),
    .int_o     (ctrl_int),
    .src_o     (ctrl_src),
    .flag_o    (cnt_flag),
    .reload_o  (reload_val),
    .load_o    (load_req),
    .ctrl_wr_o (ctrl_wr),
    .irq_o     (irq_o),
    .ctrl_rd_o (ctrl_rd),
    .load_rd_o (load_rd)
  );

  tick_timer_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_en),
    .src_i      (ctrl_src),
    .ref_tick_i (ref_tick_i),
    .load_i     (load_req),
    .reload_i   (reload_val),
    .tick_o     (tick_en),
    .expire_o   (expire),
    .cur_o      (cur_val)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic              req_user_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              irq_o,
  input logic              ctrl_en,
  input logic              cnt_flag,
  input logic              tick_en,
  input logic              load_req,
  input logic              ctrl_wr,
  input logic              expire,
  input logic [CNT_W-1:0]  cur_val,
  input logic [CNT_W-1:0]  reload_val
);
  // R2
  rsp_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R2
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R3
  ctrl_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !req_user_i && req_addr_i == ADDR_W'(0))
    |=> (rsp_rdata_o[15:3] == '0 && rsp_rdata_o[DATA_W-1:17] == '0));
  // R4
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_en && tick_en && !load_req && cur_val > CNT_W'(1))
    |=> cur_val == $past(cur_val) - 1'b1);
  // R5
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R5
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_flag);
  // R6
  zero_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && reload_val == '0 && !ctrl_wr) |=> !ctrl_en);
  // R9
  cur_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !req_user_i
     && req_addr_i == ADDR_W'(8) && !ctrl_en) |=> rsp_rdata_o == '0);
  // R10
  user_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_user_i) |=> (rsp_err_o && rsp_rdata_o == '0));
endmodule

bind tick_timer tick_timer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_user_i  (req_user_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_rdata_o (rsp_rdata_o),
  .irq_o       (irq_o),
  .ctrl_en     (ctrl_en),
  .cnt_flag    (cnt_flag),
  .tick_en     (tick_en),
  .load_req    (load_req),
  .ctrl_wr     (ctrl_wr),
  .expire      (expire),
  .cur_val     (cur_val),
  .reload_val  (reload_val)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NVEC   = 20;

  typedef struct packed {
    logic [7:0]  ticks;
    logic        wr;
    logic        user;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        exp_err;
    logic [7:0]  req;
  } vec_t;

  // each entry: reference ticks first, then one access
  localparam vec_t VEC [NVEC] = '{
    '{8'd0, 1'b0, 1'b0, 8'h00, 32'h0,        32'h0,        1'b0, 8'd1},  // R1 ctrl
    '{8'd0, 1'b0, 1'b0, 8'h04, 32'h0,        32'h0,        1'b0, 8'd1},  // R1 reload
    '{8'd0, 1'b0, 1'b0, 8'h08, 32'h0,        32'h0,        1'b0, 8'd9},  // R9 off
    '{8'd0, 1'b0, 1'b0, 8'h0C, 32'h0,        32'd10000,    1'b0, 8'd2},  // R2 calib
    '{8'd0, 1'b1, 1'b0, 8'h04, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd2},  // R2
    '{8'd0, 1'b0, 1'b0, 8'h04, 32'h0,        32'h00FFFFFF, 1'b0, 8'd2},  // R2 width
    '{8'd0, 1'b1, 1'b0, 8'h04, 32'd10,       32'h0,        1'b0, 8'd2},
    '{8'd0, 1'b1, 1'b0, 8'h00, 32'hFFFFFFF9, 32'h0,        1'b0, 8'd3},  // R3
    '{8'd0, 1'b0, 1'b0, 8'h00, 32'h0,        32'h1,        1'b0, 8'd3},  // R3 low bits only
    '{8'd4, 1'b0, 1'b0, 8'h08, 32'h0,        32'd6,        1'b0, 8'd4},  // R4 ref ticks
    '{8'd0, 1'b1, 1'b1, 8'h04, 32'd99,       32'h0,        1'b1, 8'd10}, // R10
    '{8'd0, 1'b0, 1'b0, 8'h04, 32'h0,        32'd10,       1'b0, 8'd10}, // R10 kept
    '{8'd0, 1'b0, 1'b1, 8'h00, 32'h0,        32'h0,        1'b1, 8'd10}, // R10
    '{8'd0, 1'b1, 1'b0, 8'h10, 32'd5,        32'h0,        1'b0, 8'd12}, // R12
    '{8'd0, 1'b0, 1'b0, 8'h10, 32'h0,        32'h0,        1'b0, 8'd12}, // R12
    '{8'd1, 1'b0, 1'b0, 8'h08, 32'h0,        32'd5,        1'b0, 8'd4},  // R4
    '{8'd0, 1'b1, 1'b0, 8'h08, 32'hABCD,     32'h0,        1'b0, 8'd8},  // R8
    '{8'd0, 1'b0, 1'b0, 8'h08, 32'h0,        32'd10,       1'b0, 8'd8},  // R8 restart
    '{8'd0, 1'b1, 1'b0, 8'h00, 32'h0,        32'h0,        1'b0, 8'd9},  // R9
    '{8'd3, 1'b0, 1'b0, 8'h08, 32'h0,        32'h0,        1'b0, 8'd9}   // R9
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_tick = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic              req_user = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid, rsp_err, irq;
  logic [DATA_W-1:0] rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_tick_i  (ref_tick),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_user_i  (req_user),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata),
    .rsp_err_o   (rsp_err),
    .irq_o       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; spans exactly one rising edge
  task automatic access(input logic wr, input logic user, input logic [7:0] a,
                        input logic [31:0] d, output logic [31:0] rd, output logic er);
    req_valid = 1'b1;
    req_write = wr;
    req_user  = user;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    rd = rsp_rdata;
    er = rsp_err;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_user  = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd;
    logic er;
    access(1'b1, 1'b0, a, d, rd, er);
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] rd);
    logic er;
    access(1'b0, 1'b0, a, 32'h0, rd, er);
  endtask

  task automatic ref_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic er;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      ref_ticks(int'(VEC[v].ticks));
      access(VEC[v].wr, VEC[v].user, VEC[v].addr, VEC[v].wdata, rd, er);
      chk($sformatf("R%0d vec%0d data", VEC[v].req, v), rd, VEC[v].exp);
      chk($sformatf("R%0d vec%0d err", VEC[v].req, v), {31'b0, er}, {31'b0, VEC[v].exp_err});
    end

    // R2 response valid one cycle after request
    req_valid = 1'b1; req_addr = 8'h0C;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    @(negedge clk);
    chk("R2 rsp_valid drops", {31'b0, rsp_valid}, 32'h0);

    // R5 expiry with interrupt, then R7 flag read-clear
    wr32(8'h04, 32'd3);
    wr32(8'h00, 32'h3);
    ref_ticks(2);
    chk("R5 no irq before zero", {31'b0, irq}, 32'h0);
    ref_ticks(1);
    chk("R5 irq on 1->0", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R5 irq one cycle", {31'b0, irq}, 32'h0);
    rd32(8'h08, rd);
    chk("R5 zero until next tick", rd, 32'h0);
    ref_ticks(1);
    rd32(8'h08, rd);
    chk("R5 reload on next tick", rd, 32'd3);
    rd32(8'h00, rd);
    chk("R7 flag returned", rd, 32'h10003);
    rd32(8'h00, rd);
    chk("R7 flag cleared", rd, 32'h3);

    // R5 expiry without interrupt enable
    wr32(8'h00, 32'h0);
    wr32(8'h04, 32'd1);
    wr32(8'h00, 32'h1);
    ref_ticks(1);
    chk("R5 no irq when masked", {31'b0, irq}, 32'h0);
    rd32(8'h00, rd);
    chk("R5 flag set when masked", rd, 32'h10001);

    // R8 current write clears flag and restarts
    ref_ticks(2);
    wr32(8'h08, 32'h123);
    rd32(8'h00, rd);
    chk("R8 flag cleared", rd, 32'h1);
    rd32(8'h08, rd);
    chk("R8 restart value", rd, 32'd1);

    // R6 zero reload: single expiry then stop
    wr32(8'h00, 32'h0);
    wr32(8'h04, 32'd0);
    wr32(8'h00, 32'h3);
    ref_ticks(1);
    chk("R6 irq on zero reload", {31'b0, irq}, 32'h1);
    ref_ticks(2);
    chk("R6 no second expiry", {31'b0, irq}, 32'h0);
    rd32(8'h00, rd);
    chk("R6 enable cleared", rd, 32'h10002);

    // R6 reload set to zero mid-count
    wr32(8'h04, 32'd2);
    wr32(8'h00, 32'h1);
    wr32(8'h04, 32'd0);
    ref_ticks(2);
    rd32(8'h00, rd);
    chk("R6 stop after mid-count zero", rd, 32'h10000);

    // R4 processor clock source: one decrement per cycle
    wr32(8'h04, 32'd20);
    wr32(8'h00, 32'h5);
    rd32(8'h08, rd);
    chk("R4 clock mode load", rd, 32'd20);
    rd32(8'h08, rd);
    chk("R4 clock mode decrement", rd, 32'd19);
    wr32(8'h00, 32'h0);

    // R11 source change while enabled reloads
    wr32(8'h04, 32'd8);
    wr32(8'h00, 32'h1);
    ref_ticks(3);
    rd32(8'h08, rd);
    chk("R11 before change", rd, 32'd5);
    wr32(8'h00, 32'h5);
    rd32(8'h08, rd);
    chk("R11 reloaded on change", rd, 32'd8);
    rd32(8'h08, rd);
    chk("R11 counts on clock", rd, 32'd7);
    wr32(8'h00, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule